// File: doc/BRIEF.md
# Add/Subtract-Immediate Execution Unit with Condition Flags

This unit executes one add or subtract of a 12-bit immediate against a source register value each time an instruction is issued. It decodes the 32-bit instruction word itself. The word selects the operation, an optional 12-bit left shift of the immediate, 64-bit or 32-bit width, and whether the four condition flags (negative, zero, carry, overflow) are updated. The unit returns the result, the destination index with a write enable, and a marker that tells whether destination 31 means the stack pointer. It also returns the next flag values with a flag write enable, and it keeps the current flags in a small internal register.

The outputs are registered, so every result appears one cycle after issue. The control is a two-state machine. `AS_IDLE` moves to `AS_EMIT` when `issue_valid` is high. `AS_EMIT` stays in `AS_EMIT` on another issue and returns to `AS_IDLE` when no instruction is issued. `out_valid` is high exactly in `AS_EMIT`. Encoding fields: bit 31 width, bit 30 operation, bit 29 flag-set, bits 28:23 class `100010`, bit 22 immediate shift, bits 21:10 immediate, bits 9:5 source index (unused, because the value arrives on `src_val`), and bits 4:0 destination.

Top module: `addsub_imm_alu`

## Requirements
- R1: With bit 30 clear, the result is `src_val` plus the immediate, modulo the active width.
- R2: With bit 30 set, the result is `src_val` minus the immediate, modulo the active width.
- R3: With bit 22 set, the 12-bit immediate is shifted left by 12 before use. With bit 22 clear it is used unshifted.
- R4: With bit 31 set, the operation is 64 bits wide. With bit 31 clear, only the low 32 bits of `src_val` are used, and result bits 63:32 are zero.
- R5: `flags_next` is packed as {N,Z,C,V} in bits 3..0. N is the result's top bit at the active width. Z is set when the result at the active width is zero.
- R6: C is the unsigned carry out of the active width for an add. For a subtract, C is set when no borrow occurs, that is, when the first operand is unsigned greater than or equal to the immediate.
- R7: V is set for an add when both operands have the same sign and the result sign differs. V is set for a subtract when the operand signs differ and the result sign differs from the first operand.
- R8: `flags_we` is high and `flags_q` takes `flags_next` only for a recognised instruction with bit 29 set. Otherwise `flags_q` holds its value.
- R9: With destination 31 and bit 29 clear, the write goes to the stack pointer (`rd_we`=1, `rd_is_sp`=1). With destination 31 and bit 29 set, the result is discarded (`rd_we`=0). Other destinations write normally with `rd_is_sp`=0.
- R10: A word whose bits 28:23 are not `100010` causes no register write and no flag change.
- R11: Outputs appear on the cycle after issue with `out_valid`=1. On a cycle with no preceding issue, `out_valid`, `rd_we` and `flags_we` are 0.
- R12: After reset, `out_valid`, `rd_we`, `flags_we`, `res_val` and `flags_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | First operand value |
| out_valid | output | 1 | Result outputs are meaningful |
| res_val | output | 64 | Result (upper half zero in 32-bit mode) |
| rd_idx | output | 5 | Destination index |
| rd_we | output | 1 | Destination write enable |
| rd_is_sp | output | 1 | Destination 31 denotes the stack pointer |
| flags_next | output | 4 | Computed {N,Z,C,V} |
| flags_we | output | 1 | Flag write enable |
| flags_q | output | 4 | Current flag register |

## Verification
The hardest case to reach is a 32-bit overflow or carry while the upper half of `src_val` carries unrelated bits. A unit that computed at the wrong width would agree with the reference on most inputs. The stimulus therefore places random garbage above bit 31 in every 32-bit case, and drives the exact signed and unsigned edges at both widths. It also interleaves flag-setting and non-flag-setting words, so that a stale or wrongly updated flag register shows up on the following cycle.

// File: rtl/as_alu_pkg.sv
package as_alu_pkg;
    localparam int REG_IDX_W = 5;
    localparam int FLAG_W    = 4;
    localparam int FL_N      = 3;
    localparam int FL_Z      = 2;
    localparam int FL_C      = 1;
    localparam int FL_V      = 0;

    typedef enum logic {
        AS_IDLE = 1'b0,
        AS_EMIT = 1'b1
    } as_state_t;

    typedef struct packed {
        logic                 is_op;
        logic                 is_sub;
        logic                 set_fl;
        logic                 wide;
        logic                 shift12;
        logic [REG_IDX_W-1:0] rd;
    } as_dec_t;
endpackage

// File: rtl/as_decode.sv
module as_decode
    import as_alu_pkg::*;
(
    input  logic [31:0] instr,
    output as_dec_t     dec
);
    localparam logic [5:0] CLASS_CODE = 6'b100010;

    always_comb begin
        dec.is_op   = (instr[28:23] == CLASS_CODE);
        dec.wide    = instr[31];
        dec.is_sub  = instr[30];
        dec.set_fl  = instr[29];
        dec.shift12 = instr[22];
        dec.rd      = instr[REG_IDX_W-1:0];
    end
endmodule

// File: rtl/as_arith.sv
module as_arith #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         n_fl,
    output logic         z_fl,
    output logic         c_fl,
    output logic         v_fl
);
    logic [W:0]   total;
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = total[W-1:0];
        n_fl  = sum[W-1];
        z_fl  = (sum == '0);
        c_fl  = total[W];
        if (sub)
            v_fl = (a[W-1] != b[W-1]) && (sum[W-1] != a[W-1]);
        else
            v_fl = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end

    // R6
    always_comb begin
        if (!$isunknown({a, b, sub}) && sub) begin
            borrow_carry_chk: assert (c_fl == (a >= b))
                else $error("subtract carry disagrees with unsigned compare");
        end
    end
endmodule

// File: rtl/addsub_imm_alu.sv
module addsub_imm_alu
    import as_alu_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int IMM_W     = 12,
    parameter int IMM_SHIFT = 12,
    parameter int IMM_LSB   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic [31:0]          instr,
    input  logic [XLEN-1:0]      src_val,
    output logic                 out_valid,
    output logic [XLEN-1:0]      res_val,
    output logic [REG_IDX_W-1:0] rd_idx,
    output logic                 rd_we,
    output logic                 rd_is_sp,
    output logic [FLAG_W-1:0]    flags_next,
    output logic                 flags_we,
    output logic [FLAG_W-1:0]    flags_q
);
    localparam int HALF = XLEN / 2;
    localparam logic [REG_IDX_W-1:0] SP_IDX = {REG_IDX_W{1'b1}};

    as_dec_t              dec;
    logic [IMM_W-1:0]     imm_raw;
    logic [XLEN-1:0]      imm_ext;
    logic [XLEN-1:0]      sum_wide;
    logic [HALF-1:0]      sum_narrow;
    logic [FLAG_W-1:0]    fl_wide;
    logic [FLAG_W-1:0]    fl_narrow;
    logic [XLEN-1:0]      res_c;
    logic [FLAG_W-1:0]    fl_c;
    logic                 is_top_rd;
    as_state_t            state_q;
    as_state_t            state_d;
    logic                 wide_q;

    as_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    always_comb begin
        imm_raw = instr[IMM_LSB +: IMM_W];
        imm_ext = dec.shift12 ? ({{(XLEN-IMM_W){1'b0}}, imm_raw} << IMM_SHIFT)
                              :  {{(XLEN-IMM_W){1'b0}}, imm_raw};
    end

    generate
        if (XLEN > 32) begin : g_dual
            as_arith #(.W(XLEN)) u_wide (
                .a    (src_val),
                .b    (imm_ext),
                .sub  (dec.is_sub),
                .sum  (sum_wide),
                .n_fl (fl_wide[FL_N]),
                .z_fl (fl_wide[FL_Z]),
                .c_fl (fl_wide[FL_C]),
                .v_fl (fl_wide[FL_V])
            );
        end else begin : g_single
            assign sum_wide = '0;
            assign fl_wide  = '0;
        end
    endgenerate

    as_arith #(.W(HALF)) u_narrow (
        .a    (src_val[HALF-1:0]),
        .b    (imm_ext[HALF-1:0]),
        .sub  (dec.is_sub),
        .sum  (sum_narrow),
        .n_fl (fl_narrow[FL_N]),
        .z_fl (fl_narrow[FL_Z]),
        .c_fl (fl_narrow[FL_C]),
        .v_fl (fl_narrow[FL_V])
    );

    always_comb begin
        if (dec.wide) begin
            res_c = sum_wide;
            fl_c  = fl_wide;
        end else begin
            res_c = {{(XLEN-HALF){1'b0}}, sum_narrow};
            fl_c  = fl_narrow;
        end
        is_top_rd = (dec.rd == SP_IDX);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= AS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AS_IDLE: state_d = issue_valid ? AS_EMIT : AS_IDLE;
            AS_EMIT: state_d = issue_valid ? AS_EMIT : AS_IDLE;
            default: state_d = AS_IDLE;
        endcase
    end

    assign out_valid = (state_q == AS_EMIT);

    // Output and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_val    <= '0;
            rd_idx     <= '0;
            rd_we      <= 1'b0;
            rd_is_sp   <= 1'b0;
            flags_next <= '0;
            flags_we   <= 1'b0;
            flags_q    <= '0;
            wide_q     <= 1'b0;
        end else if (issue_valid) begin
            res_val    <= res_c;
            rd_idx     <= dec.rd;
            wide_q     <= dec.wide;
            flags_next <= fl_c;
            rd_we      <= dec.is_op && !(is_top_rd && dec.set_fl);
            rd_is_sp   <= dec.is_op && is_top_rd && !dec.set_fl;
            flags_we   <= dec.is_op && dec.set_fl;
            if (dec.is_op && dec.set_fl) flags_q <= fl_c;
        end else begin
            rd_we    <= 1'b0;
            flags_we <= 1'b0;
        end
    end

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !wide_q) |-> (res_val[XLEN-1:HALF] == '0))
        else $error("narrow result has nonzero upper half");

    // R9
    zr_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags_we && rd_idx == SP_IDX) |-> (!rd_we && !rd_is_sp))
        else $error("zero-register destination was written");

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_we |=> (flags_we || $stable(flags_q)))
        else $error("flag register changed without write enable");

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!rd_we && !flags_we))
        else $error("write enable without valid output");

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags_we && wide_q) |-> (flags_next[FL_Z] == (res_val == '0)))
        else $error("zero flag disagrees with result");
endmodule

// File: tb/tb_addsub_imm_alu.sv
module tb_addsub_imm_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] src_val = '0;
    logic        out_valid;
    logic [63:0] res_val;
    logic [4:0]  rd_idx;
    logic        rd_we;
    logic        rd_is_sp;
    logic [3:0]  flags_next;
    logic        flags_we;
    logic [3:0]  flags_q;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [3:0]  m_flags = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addsub_imm_alu dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .src_val(src_val), .out_valid(out_valid), .res_val(res_val),
        .rd_idx(rd_idx), .rd_we(rd_we), .rd_is_sp(rd_is_sp),
        .flags_next(flags_next), .flags_we(flags_we), .flags_q(flags_q)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input bit sf, input bit op, input bit s,
                                        input bit sh, input logic [11:0] imm,
                                        input logic [4:0] rd);
        return {sf, op, s, 6'b100010, sh, imm, 5'd3, rd};
    endfunction

    task automatic step(input bit v, input logic [31:0] w, input logic [63:0] src);
        logic        sf, op, s, sh, good;
        logic [4:0]  rd;
        logic [63:0] imm, a, b, r;
        logic signed [65:0] ex;
        logic        n, z, c, ov;
        int          wd;
        @(negedge clk);
        issue_valid = v; instr = w; src_val = src;
        sf = w[31]; op = w[30]; s = w[29]; sh = w[22]; rd = w[4:0];
        good = (w[28:23] == 6'b100010);
        imm = {52'd0, w[21:10]};
        if (sh) imm = imm * 64'd4096;
        wd = sf ? 64 : 32;
        a = sf ? src : {32'd0, src[31:0]};
        b = sf ? imm : {32'd0, imm[31:0]};
        r = op ? a - b : a + b;
        if (!sf) r = {32'd0, r[31:0]};
        if (sf) begin
            n = r[63];
            z = (r == 0);
            c = op ? (a >= b) : (({1'b0, a} + {1'b0, b}) > 65'h0_FFFF_FFFF_FFFF_FFFF);
            ex = op ? ($signed({{2{a[63]}}, a}) - $signed({{2{b[63]}}, b}))
                    : ($signed({{2{a[63]}}, a}) + $signed({{2{b[63]}}, b}));
            ov = (ex != $signed({{2{r[63]}}, r}));
        end else begin
            n = r[31];
            z = (r[31:0] == 0);
            c = op ? (a >= b) : ((a + b) > 64'hFFFF_FFFF);
            ex = op ? ($signed({{34{a[31]}}, a[31:0]}) - $signed({{34{b[31]}}, b[31:0]}))
                    : ($signed({{34{a[31]}}, a[31:0]}) + $signed({{34{b[31]}}, b[31:0]}));
            ov = (ex != $signed({{34{r[31]}}, r[31:0]}));
        end
        @(posedge clk);
        #1;
        if (v && good && s) m_flags = {n, z, c, ov};
        chk("R11 out_valid", {63'd0, out_valid}, {63'd0, v});
        chk("R8 flags_q", {60'd0, flags_q}, {60'd0, m_flags});
        if (!v) begin
            chk("R11 rd_we idle", {63'd0, rd_we}, 64'd0);
            chk("R11 flags_we idle", {63'd0, flags_we}, 64'd0);
        end else if (!good) begin
            chk("R10 rd_we", {63'd0, rd_we}, 64'd0);
            chk("R10 flags_we", {63'd0, flags_we}, 64'd0);
        end else begin
            chk(op ? "R2 R3 R4 result" : "R1 R3 R4 result", res_val, r);
            chk("R9 rd_idx", {59'd0, rd_idx}, {59'd0, rd});
            chk("R9 rd_we", {63'd0, rd_we}, {63'd0, !(rd == 5'd31 && s)});
            chk("R9 rd_is_sp", {63'd0, rd_is_sp}, {63'd0, (rd == 5'd31 && !s)});
            chk("R8 flags_we", {63'd0, flags_we}, {63'd0, s});
            if (s) begin
                chk("R5 N", {63'd0, flags_next[3]}, {63'd0, n});
                chk("R5 Z", {63'd0, flags_next[2]}, {63'd0, z});
                chk("R6 C", {63'd0, flags_next[1]}, {63'd0, c});
                chk("R7 V", {63'd0, flags_next[0]}, {63'd0, ov});
            end
        end
        if (wd == 0) errors++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] rs;
        repeat (3) @(posedge clk);
        #1;
        chk("R12 out_valid", {63'd0, out_valid}, 64'd0);
        chk("R12 rd_we", {63'd0, rd_we}, 64'd0);
        chk("R12 flags_we", {63'd0, flags_we}, 64'd0);
        chk("R12 res_val", res_val, 64'd0);
        chk("R12 flags_q", {60'd0, flags_q}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // 64-bit corners: carry out to zero, signed overflow add, borrow, signed overflow sub
        step(1, enc(1,0,1,0,12'd1,5'd1), 64'hFFFF_FFFF_FFFF_FFFF);
        step(1, enc(1,0,1,0,12'd1,5'd2), 64'h7FFF_FFFF_FFFF_FFFF);
        step(1, enc(1,1,1,0,12'd1,5'd3), 64'h0);
        step(1, enc(1,1,1,0,12'd1,5'd4), 64'h8000_0000_0000_0000);
        step(1, enc(1,1,1,0,12'd5,5'd5), 64'd5);
        // 32-bit corners with garbage upper half
        step(1, enc(0,0,1,0,12'd1,5'd6), 64'hDEAD_BEEF_FFFF_FFFF);
        step(1, enc(0,0,1,0,12'd1,5'd7), 64'h1234_5678_7FFF_FFFF);
        step(1, enc(0,1,1,0,12'd1,5'd8), 64'hFFFF_FFFF_0000_0000);
        step(1, enc(0,1,1,0,12'd1,5'd9), 64'hA5A5_A5A5_8000_0000);
        step(1, enc(0,1,1,0,12'd7,5'd10), 64'h0000_0001_0000_0007);
        // shifted immediate at both widths
        step(1, enc(1,0,0,1,12'hABC,5'd11), 64'h0000_0001_0000_0000);
        step(1, enc(0,1,1,1,12'hFFF,5'd12), 64'h5555_5555_00FF_F000);
        // flags held when S clear
        step(1, enc(1,0,0,0,12'd9,5'd13), 64'h0);
        // destination 31 both ways
        step(1, enc(1,1,0,0,12'd16,5'd31), 64'h0000_0000_0000_1000);
        step(1, enc(1,0,1,0,12'd1,5'd31), 64'hFFFF_FFFF_FFFF_FFFF);
        // unrecognised class and idle cycles
        step(1, {enc(1,0,1,0,12'd1,5'd1)} ^ 32'h0080_0000, 64'd0);
        step(0, enc(1,0,1,0,12'd1,5'd1), 64'd0);
        step(0, '0, 64'd0);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            rs = {$urandom(), $urandom()};
            if (i % 5 == 0) rs[62:0] = {63{rs[63]}} ^ 63'd1;
            w = enc($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
                    $urandom_range(0,1), 12'($urandom()), 5'($urandom()));
            if (i % 37 == 0) w[27] = ~w[27];
            step((i % 11) != 0, w, rs);
        end
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule